// File: doc/BRIEF.md
# Port-Space Select Decoder with Graphic-Display Strobe Shaper

This block sits on the I/O side of an 8-bit CPU bus. It turns the upper address bits of an I/O access into eight active-low device selects. Each select covers an aligned window of 0x20 port addresses. The block also drives the three control lines of a parallel graphic display module: a register-select line, a direction line and an enable strobe.

The enable strobe is timed from the CPU clock and restarts with every I/O request. While the I/O request is inactive, an asynchronous clear holds a small edge counter, and the strobe with it, at zero. Once the request goes active, the strobe stays low for a set number of rising clock edges. It then goes high for a set number of edges, and it stays low after that until the request ends.

The display's direction line is the inverse of the read strobe, not a copy of the write strobe. The display therefore treats every bus state as a write, and never drives the data bus, except while a read is in progress. Each strobe phase lasts one clock period, and the display needs each phase to be at least about 450 ns. This limits the CPU clock feeding the block to about 2 MHz.

Top module: `io_strobe_decode`

## Requirements
- R1: While `iorq_n` is low, exactly one bit of `dev_sel_n` is low: bit k where k = `slot_addr` (address bits 7..5). Slot k therefore decodes ports 0x20*k to 0x20*k+0x1F.
- R2: While `iorq_n` is high, every bit of `dev_sel_n` is high, whatever the address.
- R3: The display answers on slot 1, which is `dev_sel_n[1]`. `lcd_dsel` follows address bit 0, so port 0x20 reaches the instruction register (`lcd_dsel`=0) and port 0x21 reaches display data (`lcd_dsel`=1).
- R4: `lcd_read` is the inverse of `rd_n`. It is 0 (write direction) whenever `rd_n` is high, including when no I/O request is active, and 1 only while `rd_n` is low.
- R5: `lcd_strobe` is 0 whenever `iorq_n` is high. It clears at once when `iorq_n` rises, without waiting for a clock edge.
- R6: After `iorq_n` falls, `lcd_strobe` stays 0 until the first rising edge of `cpu_clk`.
- R7: `lcd_strobe` is 1 from the first to the second rising edge of `cpu_clk` after `iorq_n` fell.
- R8: From the second rising edge onward, `lcd_strobe` stays 0 for the rest of the request, however many wait edges follow.
- R9: A new request that starts soon after the previous one ends replays the same low-high-low sequence from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock; the strobe counter advances on its rising edge |
| iorq_n | input | 1 | Active-low I/O request; when high it clears the strobe counter asynchronously |
| rd_n | input | 1 | Active-low read strobe |
| slot_addr | input | 3 | Address bits 7..5, the device slot |
| reg_addr | input | 1 | Address bit 0, the display register choice |
| dev_sel_n | output | 8 | Active-low device selects, one per slot |
| lcd_strobe | output | 1 | Display enable strobe |
| lcd_read | output | 1 | Display direction, 1 = read, 0 = write |
| lcd_dsel | output | 1 | Display register select, 0 = instruction, 1 = data |

## Verification
Two things can act on the strobe within the same clock period: the counter's clock-driven advance and the asynchronous clear on `iorq_n` rising. The bench provokes this with a request that ends one nanosecond after the first rising edge, while the strobe is high. It samples again one nanosecond later, before the next edge, and expects the strobe to be low already. Back-to-back requests, separated by a single high period of `iorq_n`, check that the clear and the next request's first edge do not combine into an early or a missing high phase.

// File: rtl/io_strobe_decode.sv
module io_strobe_decode #(
  parameter int SEL_W    = 3,
  parameter int LO_EDGES = 1,
  parameter int HI_EDGES = 1
) (
  input  logic                    cpu_clk,
  input  logic                    iorq_n,
  input  logic                    rd_n,
  input  logic [SEL_W-1:0]        slot_addr,
  input  logic                    reg_addr,
  output logic [(1<<SEL_W)-1:0]   dev_sel_n,
  output logic                    lcd_strobe,
  output logic                    lcd_read,
  output logic                    lcd_dsel
);

  localparam int NSEL = 1 << SEL_W;
  localparam int TOT  = LO_EDGES + HI_EDGES;
  localparam int CW   = $clog2(TOT + 1);

  logic [CW-1:0] edge_cnt;
  logic [CW-1:0] cnt_nx;
  logic          strobe_q;

  assign cnt_nx = edge_cnt + 1'b1;

  always_ff @(posedge cpu_clk or posedge iorq_n) begin
    if (iorq_n) begin
      edge_cnt <= '0;
      strobe_q <= 1'b0;
    end else if (edge_cnt != CW'(TOT)) begin
      edge_cnt <= cnt_nx;
      strobe_q <= (cnt_nx >= CW'(LO_EDGES)) && (cnt_nx < CW'(TOT));
    end else begin
      strobe_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign dev_sel_n[i] = iorq_n | (slot_addr != SEL_W'(i));
  end

  assign lcd_strobe = strobe_q;
  assign lcd_read   = ~rd_n;
  assign lcd_dsel   = reg_addr;

endmodule

// File: rtl/io_strobe_decode_chk.sv
module io_strobe_decode_chk #(
  parameter int SEL_W    = 3,
  parameter int HI_EDGES = 1
) (
  input logic                  cpu_clk,
  input logic                  iorq_n,
  input logic [SEL_W-1:0]      slot_addr,
  input logic [(1<<SEL_W)-1:0] dev_sel_n,
  input logic                  lcd_strobe
);

  int hi_run;

  always_ff @(posedge cpu_clk or posedge iorq_n) begin
    if (iorq_n) hi_run <= 0;
    else        hi_run <= lcd_strobe ? hi_run + 1 : 0;
  end

  // R1
  one_select_chk: assert property (@(posedge cpu_clk) disable iff (iorq_n)
    !iorq_n |-> ($countones(~dev_sel_n) == 1 && !dev_sel_n[slot_addr]));

  // R2
  idle_selects_chk: assert property (@(posedge cpu_clk) disable iff ($isunknown(iorq_n))
    iorq_n |-> (&dev_sel_n));

  // R5
  idle_strobe_chk: assert property (@(posedge cpu_clk) disable iff ($isunknown(iorq_n))
    iorq_n |-> !lcd_strobe);

  // R7
  high_width_chk: assert property (@(posedge cpu_clk) disable iff (iorq_n)
    lcd_strobe |-> (hi_run < HI_EDGES));

endmodule

bind io_strobe_decode io_strobe_decode_chk #(.SEL_W(SEL_W), .HI_EDGES(HI_EDGES)) u_chk (
  .cpu_clk   (cpu_clk),
  .iorq_n    (iorq_n),
  .slot_addr (slot_addr),
  .dev_sel_n (dev_sel_n),
  .lcd_strobe(lcd_strobe)
);

// File: tb/io_strobe_decode_bench.sv
module io_strobe_decode_bench;

  localparam int LO = 1;
  localparam int HI = 1;

  logic       clk = 1'b0;
  logic       iorq_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [2:0] slot = 3'd0;
  logic       ra = 1'b0;
  logic [7:0] sel_n;
  logic       strobe, rd_dir, dsel;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  bit run = 0;
  bit b2b = 0;
  bit done = 0;

  always #5 clk = ~clk;

  io_strobe_decode u_io_strobe_decode (
    .cpu_clk   (clk),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .slot_addr (slot),
    .reg_addr  (ra),
    .dev_sel_n (sel_n),
    .lcd_strobe(strobe),
    .lcd_read  (rd_dir),
    .lcd_dsel  (dsel)
  );

  always @(posedge clk) if (!iorq_n && edges < 1000) edges++;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_sel;
    int exp_en;
    string en_tag;
    exp_sel = iorq_n ? 8'hFF : (8'hFF & ~(1 << slot));
    exp_en  = (!iorq_n && edges >= LO && edges < LO + HI) ? 1 : 0;
    if (iorq_n)             en_tag = "R5";
    else if (b2b)           en_tag = "R9";
    else if (edges < LO)    en_tag = "R6";
    else if (edges < LO+HI) en_tag = "R7";
    else                    en_tag = "R8";
    chk(iorq_n ? "R2" : ((slot == 3'd1) ? "R3" : "R1"), int'(sel_n), exp_sel, "dev_sel_n");
    chk(en_tag, int'(strobe), exp_en, "lcd_strobe");
    chk("R4", int'(rd_dir), rd_n ? 0 : 1, "lcd_read");
    chk("R3", int'(dsel), int'(ra), "lcd_dsel");
  endtask

  always @(negedge clk) if (run) compare_all();

  task automatic io_cycle(input logic [7:0] a, input bit is_rd, input int low_edges, input bit setup);
    if (setup) begin
      @(posedge clk); #1;
      slot = a[7:5]; ra = a[0];
    end else begin
      slot = a[7:5]; ra = a[0];
    end
    @(posedge clk); #1;
    iorq_n = 1'b0; rd_n = !is_rd;
    repeat (low_edges) @(posedge clk);
    #1;
    iorq_n = 1'b1; rd_n = 1'b1; edges = 0;
    #1 compare_all();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #2 compare_all();
    run = 1;
    repeat (2) @(posedge clk);
    // R2 and R4: address and read strobe move with no request
    #1 slot = 3'd1; rd_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 slot = 3'd6; rd_n = 1'b1;
    repeat (2) @(posedge clk);
    // R3: instruction and data ports of the display, both directions
    io_cycle(8'h20, 0, 2, 1);
    io_cycle(8'h21, 0, 2, 1);
    io_cycle(8'h21, 1, 2, 1);
    io_cycle(8'h20, 1, 2, 1);
    // R8: long requests with wait edges
    io_cycle(8'h21, 0, 5, 1);
    io_cycle(8'h20, 1, 4, 1);
    // R1: every slot, with low address bits varied
    for (int k = 0; k < 8; k++) begin
      io_cycle(8'((k << 5) | (k * 3 & 8'h1F)), k[0], 3, 1);
    end
    // R5: request ends while the strobe is high
    io_cycle(8'h21, 0, 1, 1);
    io_cycle(8'h40, 1, 1, 1);
    // R9: back-to-back requests
    b2b = 1;
    for (int k = 0; k < 4; k++) begin
      io_cycle(8'h20 + 8'(k & 1), k[1], 2 + k, 0);
    end
    b2b = 0;
    repeat (3) @(posedge clk);
    #2;
    finish_up();
  end

endmodule